// File: doc/BRIEF.md
# Half-Bridge Gate Oscillator with Dead Time

This block produces the two gate enables for a half bridge from a single cycle counter. The two enables take turns with equal on-times. Between every pair of on-times there is a dead interval in which both are low. The dead interval has its own setting and does not follow the frequency.

The mode sequencer upstream provides an enable and two on-time settings: a short one for filament preheat and a long one for steady run. It also provides a blend value that moves the effective on-time between the two while the ignition ramp is in progress. The on-time is taken from the blend at the start of each on-interval. A pulse that has already started is therefore never shortened or stretched.

After every enable the first pulse goes to the low side, which lets the high-side bootstrap capacitor charge before the high side switches. A one-cycle strobe marks the start of each low-side on-interval and so gives the period.

Top module: `hb_gate_osc`

## Requirements
- R1: While the synchronous reset is high, `gate_hi`, `gate_lo` and `cycle_stb` are all 0 at every clock edge.
- R2: When `run_en` is sampled high while the block is idle, `gate_lo` goes to 1 on that same edge and `gate_hi` stays 0. The first on-interval after any enable is always on the low side.
- R3: Each on-interval lasts N clock cycles, where N = floor((pre_on*(2^BLEND_W - blend) + run_on*blend) / 2^BLEND_W). A computed value of 0 is treated as 1.
- R4: The high-side on-interval lasts the same N cycles as the low-side one when the inputs are held constant.
- R5: After each on-interval both outputs are 0 for max(dead_len, 1) cycles.
- R6: The dead interval length depends only on `dead_len` and is the same for every on-time setting.
- R7: The on-time is sampled from the inputs only on the edge that starts an on-interval. A change to `blend`, `pre_on` or `run_on` made during an interval first affects the next on-interval.
- R8: If `run_en` is sampled low, both gate outputs are 0 from that edge on and the internal timing is cleared. The next enable starts again with a full low-side on-interval.
- R9: `gate_hi` and `gate_lo` are never 1 in the same cycle.
- R10: `cycle_stb` is 1 for exactly one cycle, and that cycle is the first cycle of each low-side on-interval.
- R11: With constant inputs, the distance between consecutive strobes is 2*N + 2*max(dead_len, 1) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Oscillation enable from the mode sequencer |
| pre_on | input | ON_W | On-time in cycles for preheat (blend = 0) |
| run_on | input | ON_W | On-time in cycles for run (blend near full scale) |
| blend | input | MIX_W | Interpolation weight toward `run_on` |
| dead_len | input | DT_W | Dead interval in cycles (0 is treated as 1) |
| gate_hi | output | 1 | High-side gate enable, registered |
| gate_lo | output | 1 | Low-side gate enable, registered |
| cycle_stb | output | 1 | One-cycle marker at the start of each low-side on-interval |

## Verification
The bench builds the block with an 8-bit on-time, a 4-bit dead setting and a 4-bit blend. With these widths the extremes of every field fit into short runs: a zero on-time and zero dead time (both clamp to one cycle), a maximum blend weight, and on-times near the top of the range. The narrow blend also makes the interpolation floor easy to reach. This lets the bench exercise rounding, the clamp to one cycle, and a blend change made in the middle of a pulse, all within a handful of periods each.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LO,
    PH_GAP_A,
    PH_HI,
    PH_GAP_B
  } phase_t;
endpackage

// File: rtl/hb_on_blend.sv
module hb_on_blend #(
  parameter int ON_W  = 12,
  parameter int MIX_W = 8
) (
  input  logic [ON_W-1:0]  pre_on,
  input  logic [MIX_W-1:0] blend,
  input  logic [ON_W-1:0]  run_on,
  output logic [ON_W-1:0]  on_len
);
  localparam int AW = ON_W + MIX_W;
  localparam logic [AW-1:0] FULL = AW'(1) << MIX_W;

  logic [AW-1:0] acc;

  // weighted sum of both settings; the upper bits are the floor of the mix
  always_comb begin
    acc    = AW'(pre_on) * (FULL - AW'(blend)) + AW'(run_on) * AW'(blend);
    on_len = ON_W'(acc >> MIX_W);
  end
endmodule

// File: rtl/hb_phase_seq.sv
module hb_phase_seq
  import hb_gate_pkg::*;
#(
  parameter int ON_W = 12,
  parameter int DT_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run_en,
  input  logic [ON_W-1:0] on_len,
  input  logic [DT_W-1:0] dead_len,
  output logic            gate_hi,
  output logic            gate_lo,
  output logic            cycle_stb
);
  localparam int CW = (ON_W > DT_W) ? ON_W : DT_W;

  phase_t        st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [CW-1:0] on_m1, dt_m1;

  // lengths minus one, with zero clamped to a single cycle
  always_comb begin
    on_m1 = (on_len == '0)   ? '0 : CW'(on_len) - CW'(1);
    dt_m1 = (dead_len == '0) ? '0 : CW'(dead_len) - CW'(1);
  end

  always_comb begin
    st_n  = st_q;
    cnt_n = (cnt_q == '0) ? '0 : cnt_q - CW'(1);
    unique case (st_q)
      PH_IDLE: begin
        cnt_n = '0;
        if (run_en) begin
          st_n  = PH_LO;
          cnt_n = on_m1;
        end
      end
      PH_LO:    if (cnt_q == '0) begin st_n = PH_GAP_A; cnt_n = dt_m1; end
      PH_GAP_A: if (cnt_q == '0) begin st_n = PH_HI;    cnt_n = on_m1; end
      PH_HI:    if (cnt_q == '0) begin st_n = PH_GAP_B; cnt_n = dt_m1; end
      PH_GAP_B: if (cnt_q == '0) begin st_n = PH_LO;    cnt_n = on_m1; end
      default: begin st_n = PH_IDLE; cnt_n = '0; end
    endcase
    if (!run_en) begin
      st_n  = PH_IDLE;
      cnt_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= PH_IDLE;
      cnt_q     <= '0;
      gate_lo   <= 1'b0;
      gate_hi   <= 1'b0;
      cycle_stb <= 1'b0;
    end else begin
      st_q      <= st_n;
      cnt_q     <= cnt_n;
      gate_lo   <= (st_n == PH_LO);
      gate_hi   <= (st_n == PH_HI);
      cycle_stb <= (st_n == PH_LO) && (st_q != PH_LO);
    end
  end

  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(gate_hi && gate_lo));

  // R2
  lo_first_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_IDLE && run_en) |=> (gate_lo && !gate_hi));

  // R8
  en_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (!gate_lo && !gate_hi && cnt_q == '0));

  // R10
  stb_on_lo_chk: assert property (@(posedge clk) disable iff (rst)
    cycle_stb |-> gate_lo);

  // R10
  stb_single_chk: assert property (@(posedge clk) disable iff (rst)
    cycle_stb |=> !cycle_stb);
endmodule

// File: rtl/hb_gate_osc.sv
module hb_gate_osc #(
  parameter int ON_W  = 12,
  parameter int DT_W  = 6,
  parameter int MIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic [ON_W-1:0]  pre_on,
  input  logic [ON_W-1:0]  run_on,
  input  logic [MIX_W-1:0] blend,
  input  logic [DT_W-1:0]  dead_len,
  output logic             gate_hi,
  output logic             gate_lo,
  output logic             cycle_stb
);
  logic [ON_W-1:0] on_len;

  hb_on_blend #(.ON_W(ON_W), .MIX_W(MIX_W)) u_blend (
    .pre_on (pre_on),
    .blend  (blend),
    .run_on (run_on),
    .on_len (on_len)
  );

  hb_phase_seq #(.ON_W(ON_W), .DT_W(DT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .on_len    (on_len),
    .dead_len  (dead_len),
    .gate_hi   (gate_hi),
    .gate_lo   (gate_lo),
    .cycle_stb (cycle_stb)
  );
endmodule

// File: tb/hb_gate_osc_bench.sv
module hb_gate_osc_bench;
  localparam int ON_W = 8, DT_W = 4, MIX_W = 4;
  localparam int NV = 6;
  localparam int VP[NV] = '{5, 5, 10, 0, 200, 12};
  localparam int VR[NV] = '{40, 40, 30, 0, 100, 12};
  localparam int VB[NV] = '{0, 15, 8, 0, 4, 9};
  localparam int VD[NV] = '{3, 3, 2, 0, 7, 1};

  logic clk = 1'b0, rst = 1'b1, run_en = 1'b0;
  logic [ON_W-1:0] pre_on = '0, run_on = '0;
  logic [MIX_W-1:0] blend = '0;
  logic [DT_W-1:0] dead_len = '0;
  logic gate_hi, gate_lo, cycle_stb;
  int n_run = 0, n_fail = 0, n_overlap = 0;

  hb_gate_osc #(.ON_W(ON_W), .DT_W(DT_W), .MIX_W(MIX_W)) u_hb_gate_osc (
    .clk(clk), .rst(rst), .run_en(run_en), .pre_on(pre_on), .run_on(run_on),
    .blend(blend), .dead_len(dead_len), .gate_hi(gate_hi), .gate_lo(gate_lo),
    .cycle_stb(cycle_stb)
  );

  always #5 clk = ~clk;

  always @(negedge clk) if (gate_hi && gate_lo) n_overlap++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_on(int p, int r, int b);
    int v;
    v = (p * (16 - b) + r * b) >> 4;
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int exp_dt(int d);
    return (d < 1) ? 1 : d;
  endfunction

  task automatic count_level(input logic want_lo, input logic want_hi, output int n);
    n = 0;
    while (gate_lo == want_lo && gate_hi == want_hi && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic measure(input int p, input int r, input int b, input int d);
    int nl, nd1, nh, nd2, en_, ed;
    en_ = exp_on(p, r, b);
    ed  = exp_dt(d);
    run_en = 1'b0;
    @(negedge clk);
    pre_on = ON_W'(p); run_on = ON_W'(r); blend = MIX_W'(b); dead_len = DT_W'(d);
    run_en = 1'b1;
    @(negedge clk);
    chk(gate_lo && !gate_hi, "R2 first pulse low side", gate_lo, 1);
    chk(cycle_stb, "R10 strobe at first low pulse", cycle_stb, 1);
    count_level(1'b1, 1'b0, nl);
    chk(nl == en_, "R3 low on-time", nl, en_);
    count_level(1'b0, 1'b0, nd1);
    chk(nd1 == ed, "R5 R6 dead after low", nd1, ed);
    count_level(1'b0, 1'b1, nh);
    chk(nh == en_, "R4 high on-time", nh, en_);
    count_level(1'b0, 1'b0, nd2);
    chk(nd2 == ed, "R5 R6 dead after high", nd2, ed);
    chk(gate_lo && cycle_stb, "R10 strobe at next low pulse", cycle_stb, 1);
    chk(nl + nd1 + nh + nd2 == 2 * en_ + 2 * ed, "R11 period", nl + nd1 + nh + nd2,
        2 * en_ + 2 * ed);
    @(negedge clk);
    chk(!cycle_stb, "R10 strobe single cycle", cycle_stb, 0);
    run_en = 1'b0;
    @(negedge clk);
    chk(!gate_lo && !gate_hi, "R8 outputs low after disable", gate_lo | gate_hi, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int nl, nd, nh;
    // R1: enable held high during reset must not start the outputs
    run_en = 1'b1; pre_on = 8'd4; run_on = 8'd4;
    repeat (3) @(negedge clk);
    chk(!gate_lo && !gate_hi && !cycle_stb, "R1 reset state",
        gate_lo | gate_hi | cycle_stb, 0);
    run_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!gate_lo && !gate_hi, "R1 idle after reset", gate_lo | gate_hi, 0);

    for (int i = 0; i < NV; i++) measure(VP[i], VR[i], VB[i], VD[i]);

    // R7: blend moved in the middle of the first low pulse
    pre_on = 8'd20; run_on = 8'd60; blend = 4'd0; dead_len = 4'd2;
    run_en = 1'b1;
    @(negedge clk);
    blend = 4'd8;
    count_level(1'b1, 1'b0, nl);
    chk(nl == 20, "R7 running pulse keeps old on-time", nl, 20);
    count_level(1'b0, 1'b0, nd);
    count_level(1'b0, 1'b1, nh);
    chk(nh == 40, "R7 next pulse takes new on-time", nh, 40);

    // R8: disable in the middle of a high pulse, then restart
    run_en = 1'b0;
    count_level(1'b0, 1'b0, nd);
    run_en = 1'b1;
    @(negedge clk);
    repeat (60) @(negedge clk);
    chk(gate_hi && !gate_lo, "R8 setup in high pulse", gate_hi, 1);
    run_en = 1'b0;
    @(negedge clk);
    chk(!gate_lo && !gate_hi, "R8 immediate off", gate_lo | gate_hi, 0);
    run_en = 1'b1;
    @(negedge clk);
    chk(gate_lo && !gate_hi, "R8 R2 restart on low side", gate_lo, 1);
    count_level(1'b1, 1'b0, nl);
    chk(nl == 40, "R8 full low pulse after restart", nl, 40);
    run_en = 1'b0;
    repeat (2) @(negedge clk);

    chk(n_overlap == 0, "R9 no overlap", n_overlap, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule